// File: doc/BRIEF.md
# Address-Selected Reference Divider

This block divides a reference oscillator clock down to the comparison rate used by a phase detector. A 3-bit address input selects one of eight fixed divide ratios. The smallest ratios are powers of two. Two of the ratios, 640 and 1000, are not powers of two. A 12-bit down counter generates one single-cycle reference pulse per period of the selected ratio.

The address is sampled only when the counter reloads. A change of address therefore never shortens or stretches the period already in progress. After the active-low asynchronous reset is released, the first clock edge loads the counter from the address present at that edge. Pulses then follow at the selected ratio.

Top module: `ref_addr_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `fr_o` is low.
- R2: Address codes select these ratios: 0→8, 1→64, 2→128, 3→256, 4→640, 5→1000, 6→1024, 7→2048 (code read as an unsigned binary value of `sel_i[2:0]`).
- R3: In steady state, successive `fr_o` pulses are exactly the selected ratio of clock cycles apart.
- R4: Each `fr_o` pulse lasts exactly one clock cycle.
- R5: An address change during a period does not alter that period. The new ratio governs the period that starts at the next pulse.
- R6: The first clock edge after reset release loads the counter from the address present at that edge. The first pulse appears in the cycle that follows the edge a full ratio of edges later.
- R7: Address values applied and then withdrawn within one period, before its pulse, have no effect on that period or on the next one.
- R8: The counter never holds a value above the loaded ratio minus one, and it steps down by one on every cycle that carries no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Reference address code selecting the divide ratio |
| fr_o | output | 1 | Single-cycle reference pulse to the phase detector |

## Verification
The hardest case to reach is an address change in the middle of a period. Because of it, a design that divides correctly for a fixed code can still fail when the change lands on the wrong cycle. The stimulus waits for a pulse on a 256 ratio, counts into the period, and then moves the address to the 8 ratio. The next gap must still be 256 and the one after that 8. A second run switches the address through several codes within one period and restores it before the pulse. Both following gaps must show the original ratio.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned N_SEL = 1 << SEL_W;

  // Ascending ratio per address code.
  function automatic logic [CNT_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] r;
    unique case (code)
      3'd0: r = CNT_W'(8);
      3'd1: r = CNT_W'(64);
      3'd2: r = CNT_W'(128);
      3'd3: r = CNT_W'(256);
      3'd4: r = CNT_W'(640);
      3'd5: r = CNT_W'(1000);
      3'd6: r = CNT_W'(1024);
      default: r = CNT_W'(2048);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ref_ratio_rom.sv
module ref_ratio_rom
  import ref_div_pkg::*;
#(
  parameter int unsigned SW = SEL_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic [SW-1:0] sel_i,
  output logic [CW-1:0] term_o
);
  localparam int unsigned ENTRIES = 1 << SW;

  logic [CW-1:0] table_w [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign table_w[g] = CW'(ratio_of(SEL_W'(g)) - 1'b1);
  end

  assign term_o = table_w[sel_i];
endmodule

// File: rtl/ref_down_counter.sv
module ref_down_counter #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          armed_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          load_w;

  assign wrap_o = armed_q && (cnt_q == '0);
  assign load_w = !armed_q || wrap_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (load_w) cnt_q <= load_val_i;
      else        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/ref_addr_divider.sv
module ref_addr_divider
  import ref_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             fr_o
);
  logic [CNT_W-1:0] term_w;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             wrap_w;

  ref_ratio_rom #(.SW(SEL_W), .CW(CNT_W)) u_rom (
    .sel_i  (sel_i),
    .term_o (term_w)
  );

  ref_down_counter #(.CW(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_val_i (term_w),
    .cnt_o      (cnt_q),
    .armed_o    (armed_q),
    .wrap_o     (wrap_w)
  );

  assign fr_o = wrap_w;
endmodule

// File: rtl/ref_addr_divider_chk.sv
module ref_addr_divider_chk
  import ref_div_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] sel_i,
  input logic             fr_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             armed_i
);
  logic [CNT_W-1:0] max_q;

  // Largest value legal for the current period.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) max_q <= '0;
    else if (!armed_i || fr_o) max_q <= ratio_of(sel_i) - 1'b1;
  end

  a_r1_no_pulse_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> !fr_o);

  a_r4_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_o |=> !fr_o);

  a_r5_reload_from_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i || fr_o) |=> (cnt_i == ratio_of($past(sel_i)) - 1'b1));

  a_r8_steps_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && !fr_o) |=> (cnt_i == $past(cnt_i) - 1'b1));

  a_r8_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |-> (cnt_i <= max_q));
endmodule

bind ref_addr_divider ref_addr_divider_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .fr_o    (fr_o),
  .cnt_i   (cnt_q),
  .armed_i (armed_q)
);

// File: tb/ref_addr_divider_tb.sv
module ref_addr_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       fr;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ref_addr_divider u_dut (.clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .fr_o(fr));

  function automatic int exp_ratio(input int code);
    case (code)
      0: return 8;    1: return 64;   2: return 128;  3: return 256;
      4: return 640;  5: return 1000; 6: return 1024; default: return 2048;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count negedges until fr is seen high.
  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fr && n < 5000);
  endtask

  task automatic do_reset(input logic [2:0] code);
    @(negedge clk);
    rst_n = 1'b0;
    sel = code;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_r1_reset();
    int hi;
    @(negedge clk);
    rst_n = 1'b0;
    sel = 3'd0;
    hi = 0;
    repeat (20) begin
      @(negedge clk);
      if (fr) hi++;
    end
    check("R1 pulse during reset", hi, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle after release", int'(fr), 0);
  endtask

  task automatic t_r2_map();
    int n;
    for (int c = 0; c < 8; c++) begin
      do_reset(3'(c));
      gap(n);
      check($sformatf("R6 R2 first gap code %0d", c), n, exp_ratio(c));
      @(negedge clk);
      check("R4 pulse width", int'(fr), 0);
      gap(n);
      check($sformatf("R3 R2 steady gap code %0d", c), n + 1, exp_ratio(c));
    end
  endtask

  task automatic t_r5_change();
    int n;
    do_reset(3'd3);
    gap(n);
    repeat (100) @(negedge clk);
    sel = 3'd0;
    gap(n);
    check("R5 period in progress keeps 256", n + 100, 256);
    gap(n);
    check("R5 next period uses 8", n, 8);
    gap(n);
    check("R5 following period 8", n, 8);
  endtask

  task automatic t_r7_glitch();
    int n;
    do_reset(3'd2);
    gap(n);
    repeat (10) @(negedge clk);
    sel = 3'd7;
    repeat (5) @(negedge clk);
    sel = 3'd0;
    repeat (5) @(negedge clk);
    sel = 3'd5;
    repeat (5) @(negedge clk);
    sel = 3'd2;
    gap(n);
    check("R7 disturbed period", n + 25, 128);
    gap(n);
    check("R7 next period", n, 128);
  endtask

  task automatic t_r6_addr_at_release();
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    sel = 3'd7;
    @(negedge clk);
    sel = 3'd1;
    @(negedge clk);
    rst_n = 1'b1;
    gap(n);
    check("R6 address at release", n, 64);
  endtask

  initial begin
    t_r1_reset();
    t_r2_map();
    t_r5_change();
    t_r7_glitch();
    t_r6_addr_at_release();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule